// File: doc/BRIEF.md
# Dword Keystream Scrambler

This block whitens a stream of 32-bit data words with a pseudo-random keystream. A 16-bit linear feedback shift register, defined by the polynomial x^16+x^15+x^13+x^4+1, supplies 32 keystream bits per accepted word. Each upper and lower half of the keystream word is a fixed GF(2) matrix applied to the current 16-bit state. The data word is XORed with the keystream, so the same block both scrambles and descrambles. The generator never sees the data. Its sequence depends only on the seed and on how many words have been accepted.

A frame begins with a one-cycle restart strobe, which reloads the seed 0xF0F6. The first keystream word after seeding is 0xC2D2768D. The register advances by 32 serial steps only when a valid word is accepted, and holds over idle cycles. Deciding which words to scramble, frame parsing and CRC are left to the surrounding logic.

Top module: `scr_dword_keystream`

## Requirements
- R1: After reset, out_valid and out_data are 0 and the state holds the seed, so the first valid word, even with no restart, is XORed with 0xC2D2768D.
- R2: out_valid equals in_valid delayed by exactly one clock. When out_valid is 1, out_data equals the data word accepted one clock earlier XOR that word's keystream.
- R3: The keystream word produced from the seed 0xF0F6 is 0xC2D2768D.
- R4: Keystream bit i of the k-th word after seeding is s[32k+i] of the serial sequence s[n] = s[n-1]^s[n-3]^s[n-12]^s[n-16]. Seed bit j is s[j-16]. Consequently the upper 16 bits of one keystream word are the state used for the next word.
- R5: Cycles with in_valid low do not advance the state, so a gap between words leaves the keystream sequence unchanged.
- R6: A restart strobe reloads the seed. When it comes without a valid word, the next valid word uses 0xC2D2768D. When it comes together with a valid word, that word itself uses 0xC2D2768D.
- R7: While in_valid is low, out_data keeps its last value and in_data is ignored.
- R8: Passing the scrambled words of a frame through the block again, starting with a restart, returns the original words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | One-cycle strobe that reloads the seed at a frame start |
| in_valid | input | 1 | The word on in_data is accepted this cycle |
| in_data | input | 32 | Data word to scramble or descramble |
| out_valid | output | 1 | out_data carries a result |
| out_data | output | 32 | Registered data XOR keystream |

## Verification
The properties assume that restart and in_valid are synchronous single-bit controls that are never X after reset. They also assume the seed and polynomial parameters keep their default values, since one property compares against the fixed first keystream word. The stimulus drives every input on the falling edge and holds it for exactly one full clock. It pulses restart both alone and together with a valid word, and it fills idle gaps with junk on in_data, so the hold and ignore properties see changing inputs.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Upper bound on state and keystream widths handled by the serial model.
  localparam int unsigned MAX_W = 64;
  typedef logic [MAX_W-1:0] wide_t;

  // Feedback bit of the window-form register: parity of the tapped positions.
  function automatic logic serial_fb(wide_t win, wide_t taps);
    return ^(win & taps);
  endfunction

  // Drop the oldest bit (position 0) and insert the new one at the top.
  function automatic wide_t serial_shift(wide_t win, int unsigned sw, logic nb);
    wide_t r;
    r = win >> 1;
    r[sw-1] = nb;
    return r;
  endfunction

  // The n bits emitted by the register when started from win.
  function automatic wide_t serial_bits(wide_t win, int unsigned sw, wide_t taps,
                                        int unsigned n);
    wide_t w;
    wide_t bits;
    logic  nb;
    w    = win;
    bits = '0;
    for (int unsigned i = 0; i < n; i++) begin
      nb      = serial_fb(w, taps);
      bits[i] = nb;
      w       = serial_shift(w, sw, nb);
    end
    return bits;
  endfunction

  // The register contents after n steps when started from win.
  function automatic wide_t serial_state(wide_t win, int unsigned sw, wide_t taps,
                                         int unsigned n);
    wide_t w;
    w = win;
    for (int unsigned i = 0; i < n; i++) begin
      w = serial_shift(w, sw, serial_fb(w, taps));
    end
    return w;
  endfunction

endpackage

// File: rtl/scr_gf2_matrix.sv
// GF(2) matrix-vector product. Column j is the response of the serial register
// to a one-hot state at bit j; STATE_MODE selects whether the response is the
// emitted bit slice or the register contents after STEPS steps.
module scr_gf2_matrix #(
  parameter int unsigned      IN_W       = 16,
  parameter int unsigned      OUT_W      = 16,
  parameter int unsigned      STEPS      = 32,
  parameter int unsigned      FIRST      = 0,
  parameter bit               STATE_MODE = 1'b0,
  parameter logic [IN_W-1:0]  TAPS       = '0
) (
  input  logic [IN_W-1:0]  vec_in,
  output logic [OUT_W-1:0] vec_out
);
  import scr_pkg::*;

  localparam wide_t TAPS_W = wide_t'(TAPS);

  logic [OUT_W-1:0] col_term [IN_W];

  for (genvar j = 0; j < IN_W; j++) begin : g_col
    localparam wide_t ONEHOT = wide_t'(1) << j;
    if (STATE_MODE) begin : g_state
      localparam wide_t RESP = serial_state(ONEHOT, IN_W, TAPS_W, STEPS);
      assign col_term[j] = {OUT_W{vec_in[j]}} & RESP[OUT_W-1:0];
    end else begin : g_bits
      localparam wide_t RESP = serial_bits(ONEHOT, IN_W, TAPS_W, STEPS);
      assign col_term[j] = {OUT_W{vec_in[j]}} & RESP[FIRST +: OUT_W];
    end
  end

  always_comb begin
    vec_out = '0;
    for (int unsigned j = 0; j < IN_W; j++) begin
      vec_out = vec_out ^ col_term[j];
    end
  end

endmodule

// File: rtl/scr_state_reg.sv
// Holds the register state; restart substitutes the seed in the same cycle.
module scr_state_reg #(
  parameter int unsigned         STATE_W = 16,
  parameter logic [STATE_W-1:0]  SEED    = 16'hF0F6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               advance,
  input  logic [STATE_W-1:0] adv_state,
  output logic [STATE_W-1:0] state_q,
  output logic [STATE_W-1:0] eff_state
);

  always_comb begin
    eff_state = restart ? SEED : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (advance) begin
      state_q <= adv_state;
    end else if (restart) begin
      state_q <= SEED;
    end
  end

endmodule

// File: rtl/scr_out_stage.sv
// Output register: one clock from an accepted word to its result.
module scr_out_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] ks_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data ^ ks_word;
      end
    end
  end

endmodule

// File: rtl/scr_dword_keystream.sv
// Keystream scrambler top. WORD_W must be a multiple of STATE_W and at most
// scr_pkg::MAX_W; one matrix slice is built per STATE_W keystream bits.
module scr_dword_keystream #(
  parameter int unsigned         STATE_W = 16,
  parameter int unsigned         WORD_W  = 32,
  parameter logic [STATE_W-1:0]  TAPS    = 16'hA011,
  parameter logic [STATE_W-1:0]  SEED    = 16'hF0F6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);

  localparam int unsigned SLICES = WORD_W / STATE_W;

  // Named internal events, observed by the bound checker.
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] eff_state;
  logic [STATE_W-1:0] adv_state;
  logic [WORD_W-1:0]  ks_word;
  logic [STATE_W-1:0] ks_carry;
  logic               word_fire;

  assign word_fire = in_valid;
  assign ks_carry  = ks_word[WORD_W-1 -: STATE_W];

  scr_state_reg #(
    .STATE_W (STATE_W),
    .SEED    (SEED)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .advance   (word_fire),
    .adv_state (adv_state),
    .state_q   (state_q),
    .eff_state (eff_state)
  );

  // Keystream slices: slice s holds serial bits s*STATE_W .. (s+1)*STATE_W-1.
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    scr_gf2_matrix #(
      .IN_W       (STATE_W),
      .OUT_W      (STATE_W),
      .STEPS      ((s + 1) * STATE_W),
      .FIRST      (s * STATE_W),
      .STATE_MODE (1'b0),
      .TAPS       (TAPS)
    ) u_ks (
      .vec_in  (eff_state),
      .vec_out (ks_word[s*STATE_W +: STATE_W])
    );
  end

  // State jump of WORD_W serial steps, built independently of the slices.
  scr_gf2_matrix #(
    .IN_W       (STATE_W),
    .OUT_W      (STATE_W),
    .STEPS      (WORD_W),
    .FIRST      (0),
    .STATE_MODE (1'b1),
    .TAPS       (TAPS)
  ) u_adv (
    .vec_in  (eff_state),
    .vec_out (adv_state)
  );

  scr_out_stage #(
    .WORD_W (WORD_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (word_fire),
    .in_data   (in_data),
    .ks_word   (ks_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/scr_dword_keystream_chk.sv
module scr_dword_keystream_chk #(
  parameter int unsigned         STATE_W  = 16,
  parameter int unsigned         WORD_W   = 32,
  parameter logic [STATE_W-1:0]  SEED     = 16'hF0F6,
  parameter logic [WORD_W-1:0]   FIRST_KS = 32'hC2D2768D
) (
  input logic               clk,
  input logic               rst_n,
  input logic               restart,
  input logic               in_valid,
  input logic [WORD_W-1:0]  in_data,
  input logic               out_valid,
  input logic [WORD_W-1:0]  out_data,
  input logic [STATE_W-1:0] state_q,
  input logic [STATE_W-1:0] ks_carry
);

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  assert_hold_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !restart) |=> $stable(state_q));

  assert_reseed_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !in_valid) |=> (state_q == SEED));

  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && in_valid) |=> (out_data == ($past(in_data) ^ FIRST_KS)));

  assert_carry_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (state_q == $past(ks_carry)));

endmodule

bind scr_dword_keystream scr_dword_keystream_chk #(
  .STATE_W (STATE_W),
  .WORD_W  (WORD_W),
  .SEED    (SEED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .state_q   (state_q),
  .ks_carry  (ks_carry)
);

// File: tb/scr_dword_keystream_test.sv
module scr_dword_keystream_test;

  localparam int unsigned       SW       = 16;
  localparam int unsigned       WW       = 32;
  localparam logic [SW-1:0]     SEED_V   = 16'hF0F6;
  localparam logic [WW-1:0]     FIRST_KS = 32'hC2D2768D;
  localparam int unsigned       WD_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          restart = 1'b0;
  logic          in_valid = 1'b0;
  logic [WW-1:0] in_data = '0;
  logic          out_valid;
  logic [WW-1:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  scr_dword_keystream uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int unsigned   n_run  = 0;
  int unsigned   n_fail = 0;
  int unsigned   cyc    = 0;
  bit            mon_on = 1'b0;
  bit            done   = 1'b0;

  logic [WW-1:0] exp_q [$];
  string         tag_q [$];
  int unsigned   at_q  [$];
  bit            hist  [$];
  logic [WW-1:0] last_out = '0;
  logic [WW-1:0] m_exp;
  string         m_tag;
  int unsigned   m_at;

  task automatic check(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: serial sequence with s[n] = s[n-1]^s[n-3]^s[n-12]^s[n-16] (R4).
  task automatic model_seed();
    hist.delete();
    for (int j = 0; j < SW; j++) hist.push_back(SEED_V[j]);
  endtask

  task automatic model_word(output logic [WW-1:0] ks);
    for (int i = 0; i < WW; i++) begin
      int n;
      bit nb;
      n  = hist.size();
      nb = hist[n-1] ^ hist[n-3] ^ hist[n-12] ^ hist[n-16];
      hist.push_back(nb);
      ks[i] = nb;
    end
    while (hist.size() > SW) void'(hist.pop_front());
  endtask

  // Driver: present one valid word and push its expected result.
  task automatic send(input logic [WW-1:0] d, input bit rs, input bit fixed,
                      input logic [WW-1:0] fexp, input string tag,
                      output logic [WW-1:0] scr);
    logic [WW-1:0] ks;
    @(negedge clk);
    if (rs) model_seed();
    model_word(ks);
    scr      = d ^ ks;
    restart  = rs;
    in_valid = 1'b1;
    in_data  = d;
    exp_q.push_back(fixed ? fexp : scr);
    tag_q.push_back(tag);
    at_q.push_back(cyc);
  endtask

  // Idle cycles with junk data; optional restart in the first one.
  task automatic quiet(input int n, input bit rs);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      restart  = rs && (i == 0);
      in_data  = 32'hDEAD_0000 | WW'(i * 32'h0101);
      if (rs && i == 0) model_seed();
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // Monitor: scoreboard compare, latency and idle hold.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 out_valid with nothing expected", out_data, '0);
        end else begin
          m_exp = exp_q.pop_front();
          m_tag = tag_q.pop_front();
          m_at  = at_q.pop_front();
          check(out_data === m_exp, m_tag, out_data, m_exp);
          check(cyc == m_at + 1, {m_tag, " R2 latency"}, WW'(cyc), WW'(m_at + 1));
          last_out = out_data;
        end
      end else begin
        check(out_data === last_out, "R7 out_data held while idle", out_data, last_out);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] scr;
    logic [WW-1:0] frame_d [5];
    logic [WW-1:0] frame_s [5];
    model_seed();
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", WW'(out_valid), '0);
    check(out_data == '0, "R1 out_data after reset", out_data, '0);
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // R1 R3: first word straight from the reset seed, no restart.
    send(32'h0, 1'b0, 1'b1, FIRST_KS, "R1 R3 first keystream from reset seed", scr);
    // R2 R4: back-to-back words with distinct patterns.
    send(32'hFFFF_FFFF, 1'b0, 1'b0, '0, "R2 R4 all ones", scr);
    send(32'hA5A5_5A5A, 1'b0, 1'b0, '0, "R2 R4 alternating", scr);
    send(32'h0000_0001, 1'b0, 1'b0, '0, "R2 R4 single bit", scr);
    quiet(1, 1'b0);
    // R5 R7: gaps do not advance the sequence, junk data ignored.
    send(32'h1357_9BDF, 1'b0, 1'b0, '0, "R5 word before gap", scr);
    quiet(4, 1'b0);
    send(32'h0, 1'b0, 1'b0, '0, "R5 R4 word after gap", scr);
    quiet(2, 1'b0);
    // R6: restart alone, then first word uses the seed keystream.
    quiet(1, 1'b1);
    quiet(2, 1'b0);
    send(32'h0, 1'b0, 1'b1, FIRST_KS, "R6 restart while idle", scr);
    send(32'hCAFE_F00D, 1'b0, 1'b0, '0, "R6 R4 word after restart", scr);
    // R3 R6: restart together with a valid word.
    send(32'h1234_5678, 1'b1, 1'b1, 32'h1234_5678 ^ FIRST_KS,
         "R3 R6 restart with valid word", scr);
    send(32'h8765_4321, 1'b0, 1'b0, '0, "R4 continues after restart", scr);
    quiet(1, 1'b0);
    // R8: scramble a frame, then descramble it.
    for (int i = 0; i < 5; i++) begin
      frame_d[i] = 32'h0F1E_2D3C * WW'(i + 1) ^ WW'(i);
      send(frame_d[i], i == 0, 1'b0, '0, "R8 scramble frame", frame_s[i]);
    end
    quiet(2, 1'b0);
    for (int i = 0; i < 5; i++) begin
      send(frame_s[i], i == 0, 1'b1, frame_d[i], "R8 descramble restores data", scr);
    end
    quiet(3, 1'b0);
    check(exp_q.size() == 0, "R2 every accepted word produced a result",
          WW'(exp_q.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule